// File: doc/BRIEF.md
# Packed Float-to-Integer Truncating Converter

The block takes one 64-bit word that carries two IEEE-754 single-precision numbers and turns each into a signed 32-bit integer. Each conversion rounds toward zero. The two integers are packed back into a 64-bit result, so the low float becomes the low integer and the high float becomes the high integer. Each lane detects its own special cases: NaN, infinity, out-of-range values, zeros, denormals and values smaller than one. The lane conditions are merged into one invalid flag and one precision flag.

An invalid-mask input decides what happens when a lane cannot be represented. With the mask set, that lane writes the integer-indefinite pattern and the result is still written. With the mask clear, the result write is withheld and a fault is raised. Every accepted operation also signals the side effects of entering packed-integer mode: a strobe, a stack-top value of zero and an all-zero tag word, which the surrounding register file applies. Results, flags and the write-enable appear one clock after the input is accepted.

Top module: `pk_f2i_trunc`

## Requirements
- R1: Source bits 31:0 convert into result bits 31:0, and source bits 63:32 convert into result bits 63:32. The lanes do not affect each other.
- R2: A finite in-range value with a nonzero fraction returns its integer part truncated toward zero. For example, 2.7 gives 2 and -2.7 gives -2.
- R3: A lane is invalid when its input is NaN (exponent field 255, fraction nonzero) or infinity (exponent field 255, fraction zero), or when its truncation is at least 2^31 or below -2^31. An input of exactly -2^31 (bit pattern 0xCF000000) gives 0x80000000 and is not invalid.
- R4: With inv_mask high, an invalid lane writes 0x80000000, and dst_we is high.
- R5: Zero and denormal inputs (exponent field 0) give 0, and so does any value whose magnitude is below 1. A nonzero denormal and any nonzero value below 1 in magnitude set precision.
- R6: flag_invalid is the OR of the lane invalid conditions. flag_precision is the OR of the lane precision conditions, counting only lanes that are not invalid.
- R7: With inv_mask low and at least one invalid lane, dst_we is low, fault is high and dst is 0. Otherwise, for an accepted operation, dst_we is high and fault is low.
- R8: Outputs update one clock after an accepted input (in_valid high). In a cycle after no input, out_valid, dst_we, fault, both flags and mode_strobe are low, and dst holds its previous value.
- R9: Every accepted operation raises mode_strobe together with out_valid, with tos_out equal to 0 and tag_out equal to all zeros.
- R10: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand is present this cycle |
| src | input | 64 | Two packed single-precision values |
| inv_mask | input | 1 | High: invalid lanes write the indefinite value |
| out_valid | output | 1 | Result cycle for an accepted operand |
| dst | output | 64 | Two packed signed 32-bit integers |
| dst_we | output | 1 | Destination write-enable |
| fault | output | 1 | Unmasked invalid; write withheld |
| flag_invalid | output | 1 | Merged invalid condition |
| flag_precision | output | 1 | Merged inexact condition |
| mode_strobe | output | 1 | Apply packed-integer mode side effects |
| tos_out | output | 3 | Stack-top value to load (always 0) |
| tag_out | output | 16 | Tag word to load (all zeros) |

## Verification
The bench sweeps every exponent code with both signs and a set of fraction patterns. Each lane gets a different word, so a lane swap or a lane that leaks into its neighbour shows up. The sweep covers zeros, denormals, values just below one, values exact and inexact in the integer range, the edge at 2^31 and its exact negative form, infinities and NaNs. It shows whether truncation, the indefinite substitute and the precision suppression are each applied in the right category. Directed cases at ±2.7, ±2^31 and idle cycles test rounding direction and hold behaviour. Alternating the mask tests the write-withhold path against the substitute path.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int FP_W  = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int INT_W = 32;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

  typedef struct packed {
    logic             inv;
    logic             prec;
    logic [INT_W-1:0] val;
  } lane_res_t;
endpackage

// File: rtl/f2i_lane.sv
module f2i_lane
  import f2i_pkg::*;
(
  input  logic [FP_W-1:0] x,
  output lane_res_t       r
);
  localparam int SH_W = MAN_W + INT_W;
  localparam logic [EXP_W-1:0] E_ALL1  = '1;
  localparam logic [EXP_W-1:0] E_BIAS  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] E_EDGE  = EXP_W'(BIAS + INT_W - 1);

  logic             sgn;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;
  logic [MAN_W:0]   mant;
  logic [SH_W-1:0]  wide;
  logic [INT_W-1:0] mag;
  logic [EXP_W-1:0] sh;

  assign sgn  = x[FP_W-1];
  assign expo = x[FP_W-2 -: EXP_W];
  assign frac = x[MAN_W-1:0];
  assign mant = {1'b1, frac};
  assign sh   = expo - E_BIAS;
  assign wide = {{(SH_W-MAN_W-1){1'b0}}, mant} << sh;
  assign mag  = wide[MAN_W +: INT_W];

  always_comb begin
    r = '0;
    if (expo == E_ALL1) begin
      r.inv = 1'b1;
    end else if (expo == '0) begin
      r.prec = |frac;
    end else if (expo < E_BIAS) begin
      r.prec = 1'b1;
    end else if (expo >= E_EDGE) begin
      if (expo == E_EDGE && sgn && frac == '0)
        r.val = {1'b1, {(INT_W-1){1'b0}}};
      else
        r.inv = 1'b1;
    end else begin
      r.prec = |wide[MAN_W-1:0];
      r.val  = sgn ? (~mag + INT_W'(1)) : mag;
    end
  end
endmodule

// File: rtl/f2i_merge.sv
module f2i_merge
  import f2i_pkg::*;
#(
  parameter int LANES = 2
)(
  input  lane_res_t              lr [LANES],
  input  logic                   inv_mask,
  output logic [LANES*INT_W-1:0] nxt_dst,
  output logic                   nxt_we,
  output logic                   nxt_fault,
  output logic                   nxt_inv,
  output logic                   nxt_prec
);
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  logic [LANES*INT_W-1:0] packed_v;

  always_comb begin
    nxt_inv  = 1'b0;
    nxt_prec = 1'b0;
    packed_v = '0;
    for (int i = 0; i < LANES; i++) begin
      nxt_inv  = nxt_inv | lr[i].inv;
      nxt_prec = nxt_prec | (lr[i].prec & ~lr[i].inv);
      packed_v[i*INT_W +: INT_W] = lr[i].inv ? INDEF : lr[i].val;
    end
    nxt_fault = nxt_inv & ~inv_mask;
    nxt_we    = ~nxt_fault;
    nxt_dst   = nxt_fault ? '0 : packed_v;
  end
endmodule

// File: rtl/pk_f2i_trunc.sv
module pk_f2i_trunc
  import f2i_pkg::*;
#(
  parameter int LANES = 2,
  parameter int TOS_W = 3,
  parameter int TAG_W = 16,
  localparam int DW   = LANES * INT_W
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DW-1:0]    src,
  input  logic             inv_mask,
  output logic             out_valid,
  output logic [DW-1:0]    dst,
  output logic             dst_we,
  output logic             fault,
  output logic             flag_invalid,
  output logic             flag_precision,
  output logic             mode_strobe,
  output logic [TOS_W-1:0] tos_out,
  output logic [TAG_W-1:0] tag_out
);
  lane_res_t     lr [LANES];
  logic [DW-1:0] nxt_dst;
  logic          nxt_we, nxt_fault, nxt_inv, nxt_prec;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    f2i_lane u_lane (
      .x (src[g*FP_W +: FP_W]),
      .r (lr[g])
    );
  end

  f2i_merge #(.LANES(LANES)) u_merge (
    .lr        (lr),
    .inv_mask  (inv_mask),
    .nxt_dst   (nxt_dst),
    .nxt_we    (nxt_we),
    .nxt_fault (nxt_fault),
    .nxt_inv   (nxt_inv),
    .nxt_prec  (nxt_prec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      dst            <= '0;
      dst_we         <= 1'b0;
      fault          <= 1'b0;
      flag_invalid   <= 1'b0;
      flag_precision <= 1'b0;
      mode_strobe    <= 1'b0;
      tos_out        <= '0;
      tag_out        <= '0;
    end else begin
      out_valid      <= in_valid;
      dst_we         <= in_valid & nxt_we;
      fault          <= in_valid & nxt_fault;
      flag_invalid   <= in_valid & nxt_inv;
      flag_precision <= in_valid & nxt_prec;
      mode_strobe    <= in_valid;
      if (in_valid) begin
        dst     <= nxt_dst;
        tos_out <= '0;
        tag_out <= '0;
      end
    end
  end
endmodule

// File: rtl/f2i_chk.sv
module f2i_chk
  import f2i_pkg::*;
#(
  parameter int LANES = 2,
  parameter int TOS_W = 3,
  parameter int TAG_W = 16
)(
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   inv_mask,
  input logic                   out_valid,
  input logic [LANES*INT_W-1:0] dst,
  input logic                   dst_we,
  input logic                   fault,
  input logic                   flag_invalid,
  input logic                   flag_precision,
  input logic                   mode_strobe,
  input logic [TOS_W-1:0]       tos_out,
  input logic [TAG_W-1:0]       tag_out
);
  logic any_indef;
  always_comb begin
    any_indef = 1'b0;
    for (int i = 0; i < LANES; i++)
      any_indef = any_indef | (dst[i*INT_W +: INT_W] == {1'b1, {(INT_W-1){1'b0}}});
  end

  a_r7_we_fault_excl: assert property (@(posedge clk) disable iff (rst)
    !(dst_we && fault));

  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !dst_we && !fault && !flag_invalid
                   && !flag_precision && !mode_strobe && $stable(dst)));

  a_r9_side_fx: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (mode_strobe && tos_out == '0 && tag_out == '0));

  a_r4_indef: assert property (@(posedge clk) disable iff (rst)
    (out_valid && dst_we && flag_invalid) |-> any_indef);

  a_r7_unmasked: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !inv_mask) |=> (fault == flag_invalid));

  a_r7_fault_zero: assert property (@(posedge clk) disable iff (rst)
    fault |-> (dst == '0 && flag_invalid));
endmodule

bind pk_f2i_trunc f2i_chk #(.LANES(LANES), .TOS_W(TOS_W), .TAG_W(TAG_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .inv_mask       (inv_mask),
  .out_valid      (out_valid),
  .dst            (dst),
  .dst_we         (dst_we),
  .fault          (fault),
  .flag_invalid   (flag_invalid),
  .flag_precision (flag_precision),
  .mode_strobe    (mode_strobe),
  .tos_out        (tos_out),
  .tag_out        (tag_out)
);

// File: tb/sim_pk_f2i_trunc.sv
`timescale 1ns/1ps
module sim_pk_f2i_trunc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] src = '0;
  logic        inv_mask = 1'b1;
  logic        out_valid, dst_we, fault, flag_invalid, flag_precision, mode_strobe;
  logic [63:0] dst;
  logic [2:0]  tos_out;
  logic [15:0] tag_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pk_f2i_trunc u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .inv_mask(inv_mask),
    .out_valid(out_valid), .dst(dst), .dst_we(dst_we), .fault(fault),
    .flag_invalid(flag_invalid), .flag_precision(flag_precision),
    .mode_strobe(mode_strobe), .tos_out(tos_out), .tag_out(tag_out)
  );

  // Independent reference: returns {inv, prec, value}
  function automatic logic [33:0] ref_conv(input logic [31:0] x);
    logic        s;
    int          e;
    logic [63:0] m, v;
    logic        inv, prec;
    logic [31:0] val;
    s = x[31]; e = int'(x[30:23]); m = {40'd0, 1'b1, x[22:0]};
    inv = 0; prec = 0; val = 0;
    if (e == 255) inv = 1;
    else if (e == 0) prec = (x[22:0] != 0);
    else if (e >= 158) begin
      if (e == 158 && s && x[22:0] == 0) val = 32'h8000_0000;
      else inv = 1;
    end else begin
      if (e >= 150) v = m << (e - 150);
      else begin
        v = m >> (150 - e);
        prec = ((v << (150 - e)) != m);
      end
      val = s ? 32'(-v) : v[31:0];
    end
    return {inv, prec, val};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [63:0] a, input logic m, input string req);
    logic [33:0] r0, r1;
    logic        einv, eprec, efault, ewe;
    logic [63:0] edst;
    r0 = ref_conv(a[31:0]);
    r1 = ref_conv(a[63:32]);
    einv  = r0[33] | r1[33];
    eprec = (r0[32] & ~r0[33]) | (r1[32] & ~r1[33]);
    efault = einv & ~m;
    ewe = ~efault;
    edst = efault ? 64'd0 :
           {r1[33] ? 32'h8000_0000 : r1[31:0], r0[33] ? 32'h8000_0000 : r0[31:0]};
    @(negedge clk);
    src = a; inv_mask = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(dst == edst, {req, " R1 dst"}, dst, edst);
    chk({dst_we, fault} == {ewe, efault}, "R7 we/fault", {62'd0, dst_we, fault}, {62'd0, ewe, efault});
    chk({flag_invalid, flag_precision} == {einv, eprec}, "R6 flags",
        {62'd0, flag_invalid, flag_precision}, {62'd0, einv, eprec});
    chk(out_valid && mode_strobe && tos_out == 0 && tag_out == 0, "R9 side effects",
        {44'd0, out_valid, mode_strobe, tos_out, tag_out}, {44'd0, 2'b11, 19'd0});
  endtask

  function automatic logic [22:0] pick_frac(input int k);
    case (k)
      0: return 23'h000000;
      1: return 23'h000001;
      2: return 23'h400000;
      3: return 23'h7FFFFF;
      default: return 23'h123456;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({out_valid, dst_we, fault, flag_invalid, flag_precision, mode_strobe} == 0
        && dst == 0 && tos_out == 0 && tag_out == 0, "R10 reset", dst, 64'd0);
    rst = 1'b0;

    // R2 directed truncation: 2.7 and -2.7
    do_op({32'hC02C_CCCD, 32'h402C_CCCD}, 1'b1, "R2 trunc");
    chk(dst == {32'hFFFF_FFFE, 32'h0000_0002}, "R2 +-2.7", dst, {32'hFFFF_FFFE, 32'h0000_0002});
    // R3 exact -2^31 and +2^31
    do_op({32'h4F00_0000, 32'hCF00_0000}, 1'b1, "R3 edge");
    chk(dst == {32'h8000_0000, 32'h8000_0000} && flag_invalid, "R3 edge values", dst, {32'h8000_0000, 32'h8000_0000});
    do_op({32'h3F80_0000, 32'hCF00_0000}, 1'b1, "R3 exact min");
    chk(!flag_invalid && dst[31:0] == 32'h8000_0000, "R3 -2^31 valid", dst, {32'h1, 32'h8000_0000});
    // R3/R4 NaN and infinity
    do_op({32'h7FC0_0000, 32'hFF80_0000}, 1'b1, "R4 nan/inf");
    // R5 denormal and 0.5
    do_op({32'h3F00_0000, 32'h0000_0001}, 1'b1, "R5 small");
    chk(dst == 0 && flag_precision, "R5 small values", dst, 64'd0);
    // R7 unmasked invalid
    do_op({32'h4000_0000, 32'h7F80_0000}, 1'b0, "R7 unmasked");
    // R6 precision suppressed on invalid lane, other lane exact
    do_op({32'h4000_0000, 32'h7F80_0001}, 1'b1, "R6 suppress");
    chk(!flag_precision, "R6 no prec", {63'd0, flag_precision}, 64'd0);
    // R8 idle cycle holds dst
    held = dst;
    @(negedge clk);
    chk(!out_valid && !dst_we && !fault && !flag_invalid && !flag_precision && !mode_strobe
        && dst == held, "R8 idle hold", dst, held);

    // Sweep: all exponents, both signs, several fractions
    for (int e = 0; e < 256; e++) begin
      for (int k = 0; k < 5; k++) begin
        for (int s = 0; s < 2; s++) begin
          logic [31:0] l0, l1;
          logic [7:0]  e1;
          e1 = 8'(e) ^ 8'h01;
          l0 = {1'(s), 8'(e), pick_frac(k)};
          l1 = {~1'(s), e1, pick_frac(4 - k)};
          do_op({l1, l0}, (e % 7) != 0, "R2 R3 R4 R5 sweep");
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule